// File: doc/BRIEF.md
# Start-Up Bias Hysteresis Controller

This block decides when an external start-up pass device should feed the bias rail of a power-factor stage. It watches a digitized bias-rail sense code (one LSB per millivolt) and drives a single control level: low turns the pass device on and recharges the rail, high turns it off. It also tells the switching logic when PFC switching may run during start-up, and it counts how often a start-up ramp is cut short by a sagging rail.

The hysteresis window depends on the operating mode. In start-up the level waits for the rail to reach the upper threshold after any sag. In normal regulation it is held high. In light-load burst operation it follows a narrow window just above the lower threshold. Every threshold decision is confirmed by two consecutive agreeing samples. A force-low request from the fault supervisor overrides everything. After a bounded number of interrupted ramps the block latches into a shutdown state that only reset clears.

Top module: `bias_hyst_ctrl`

## Requirements
- R1: After reset `bias_ctrl`, `sw_allow`, `restart_pulse` and `restart_exhausted` are 0. `bias_ctrl` stays 0, in every mode, until the filtered code is first at or above 913.
- R2: In start-up mode (`mode` = 2'b00), a high `bias_ctrl` falls when the code is below 457. It rises again only once the code is at or above 913. Between 457 and 912 it holds. `sw_allow` equals `bias_ctrl` in this mode.
- R3: A threshold crossing needs two consecutive agreeing samples. An excursion that lasts a single cycle leaves the outputs unchanged. A sustained crossing first shows on the outputs after the third rising clock edge following the change of `bias_code`.
- R4: Each fall of `bias_ctrl` in start-up mode while `ramp_done` is 0 is one restart and gives a one-cycle `restart_pulse`, in the same cycle as the fall. A fall while `ramp_done` is 1 gives no pulse and is not counted.
- R5: The tenth counted restart raises `restart_exhausted` in the same cycle as its pulse. The flag then stays 1, and `bias_ctrl` and `sw_allow` stay 0 in every mode, until reset.
- R6: In normal mode (`mode` = 2'b01), once primed, `bias_ctrl` and `sw_allow` are 1 whatever the code.
- R7: In burst mode (`mode` = 2'b10), `bias_ctrl` falls below 457 and rises above 495 (496 and up), and holds between these. `sw_allow` is 1 in this mode once primed.
- R8: `force_low` drives `bias_ctrl` and `sw_allow` to 0 at the next rising edge. A rail sag seen while forced is not counted as a restart.
- R9: `mode` = 2'b11 behaves as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bias_code | input | 10 | Bias-rail sense code, 1 LSB = 1 mV |
| mode | input | 2 | 00 start-up, 01 normal, 10 burst, 11 as normal |
| ramp_done | input | 1 | Start-up ramp has reached its end point |
| force_low | input | 1 | Fault supervisor override, holds outputs low |
| bias_ctrl | output | 1 | Pass-device control level (low = device on) |
| sw_allow | output | 1 | PFC switching allowed |
| restart_pulse | output | 1 | One-cycle pulse per counted ramp restart |
| restart_exhausted | output | 1 | Restart budget used up, latched shutdown |

## Verification
Restart counting and the force-low override both act on the same falling edge of the control level, so they can coincide. The bench provokes this by raising `force_low` in the very cycle it drops the code below 457 with `ramp_done` low. It then checks that the level is low one edge later and that the running pulse count has not moved, through the release of the force and the later recovery. A second coincidence is the tenth restart. There the pulse and the exhausted flag must appear together, and a monitor sampling between edges records whether they did.

// File: rtl/bias_hyst_pkg.sv
// Package: shared types for the start-up bias hysteresis controller.
// Assumes the mode encoding is fixed by the mode sequencer upstream.
package bias_hyst_pkg;

    typedef enum logic [1:0] {
        MODE_START = 2'b00,
        MODE_NORM  = 2'b01,
        MODE_BURST = 2'b10,
        MODE_ALT   = 2'b11
    } op_mode_e;

    // Comparison kind for a threshold filter.
    typedef enum logic [1:0] {
        CMP_GE = 2'b00,
        CMP_LT = 2'b01,
        CMP_GT = 2'b10
    } cmp_kind_e;

endpackage

// File: rtl/bias_cmp_filter.sv
// Module: bias_cmp_filter
// Compares the sense code against one fixed threshold. The filtered flag
// moves only when two consecutive raw results agree.
// Assumes the code is synchronous to clk. Both registers reset to 0.
module bias_cmp_filter
    import bias_hyst_pkg::*;
#(
    parameter int        CODE_W = 10,
    parameter int        THRESH = 512,
    parameter cmp_kind_e KIND   = CMP_GE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              flag
);

    localparam logic [CODE_W-1:0] TH_C = CODE_W'(THRESH);

    logic raw;
    logic samp_q;
    logic flag_q;

    // Raw comparison, variant chosen by KIND.
    generate
        if (KIND == CMP_GE) begin : g_ge
            assign raw = (code >= TH_C);
        end else if (KIND == CMP_LT) begin : g_lt
            assign raw = (code < TH_C);
        end else begin : g_gt
            assign raw = (code > TH_C);
        end
    endgenerate

    // Keep the previous raw sample and update the flag on two agreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            samp_q <= raw;
            if (raw == samp_q) begin
                flag_q <= raw;
            end
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/bias_restart_cnt.sv
// Module: bias_restart_cnt
// Saturating count of ramp restarts. Flags exhaustion at MAX_RESTARTS.
// Assumes inc is a single-cycle request. The count clears only on reset.
module bias_restart_cnt #(
    parameter int MAX_RESTARTS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic exhausted
);

    localparam int CNT_W = $clog2(MAX_RESTARTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RESTARTS);

    logic [CNT_W-1:0] cnt_q;

    // Count restarts up to the limit and then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exhausted = (cnt_q == CNT_MAX);

endmodule

// File: rtl/bias_hyst_ctrl.sv
// Module: bias_hyst_ctrl (top)
// Drives the start-up pass-device control level from a filtered bias code.
// Mode-dependent hysteresis, start-up switching gate, bounded restart count
// and a force-low override. All outputs are registered.
// Assumes bias_code and the control inputs are synchronous to clk.
module bias_hyst_ctrl
    import bias_hyst_pkg::*;
#(
    parameter int CODE_W       = 10,
    parameter int TH_HIGH      = 913,
    parameter int TH_LOW       = 457,
    parameter int TH_BURST     = 495,
    parameter int MAX_RESTARTS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] bias_code,
    input  logic [1:0]        mode,
    input  logic              ramp_done,
    input  logic              force_low,
    output logic              bias_ctrl,
    output logic              sw_allow,
    output logic              restart_pulse,
    output logic              restart_exhausted
);

    op_mode_e mode_e;
    logic     hi_f, lo_f, bu_f;
    logic     lvl_q, lvl_n;
    logic     sw_q, sw_n;
    logic     pulse_q, pulse_n;
    logic     primed_q, primed_n;
    logic     exh;

    assign mode_e = op_mode_e'(mode);

    // Filtered "reached upper threshold" decision.
    bias_cmp_filter #(.CODE_W(CODE_W), .THRESH(TH_HIGH), .KIND(CMP_GE)) u_hi (
        .clk(clk), .rst_n(rst_n), .code(bias_code), .flag(hi_f)
    );

    // Filtered "below lower threshold" decision.
    bias_cmp_filter #(.CODE_W(CODE_W), .THRESH(TH_LOW), .KIND(CMP_LT)) u_lo (
        .clk(clk), .rst_n(rst_n), .code(bias_code), .flag(lo_f)
    );

    // Filtered "above burst release threshold" decision.
    bias_cmp_filter #(.CODE_W(CODE_W), .THRESH(TH_BURST), .KIND(CMP_GT)) u_bu (
        .clk(clk), .rst_n(rst_n), .code(bias_code), .flag(bu_f)
    );

    // Restart budget.
    bias_restart_cnt #(.MAX_RESTARTS(MAX_RESTARTS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(pulse_n), .exhausted(exh)
    );

    // Next control level, priming state and restart request.
    always_comb begin
        lvl_n    = lvl_q;
        primed_n = primed_q;
        pulse_n  = 1'b0;
        if (force_low || exh) begin
            lvl_n = 1'b0;
        end else if (!primed_q) begin
            if (hi_f) begin
                lvl_n    = 1'b1;
                primed_n = 1'b1;
            end
        end else begin
            unique case (mode_e)
                MODE_START: begin
                    if (lvl_q && lo_f) begin
                        lvl_n   = 1'b0;
                        pulse_n = !ramp_done;
                    end else if (!lvl_q && hi_f) begin
                        lvl_n = 1'b1;
                    end
                end
                MODE_BURST: begin
                    if (lo_f) begin
                        lvl_n = 1'b0;
                    end else if (bu_f) begin
                        lvl_n = 1'b1;
                    end
                end
                MODE_NORM, MODE_ALT: begin
                    lvl_n = 1'b1;
                end
                default: lvl_n = 1'b1;
            endcase
        end
    end

    // Switching permission follows the level only during start-up.
    always_comb begin
        if (force_low || exh || !primed_n) begin
            sw_n = 1'b0;
        end else if (mode_e == MODE_START) begin
            sw_n = lvl_n;
        end else begin
            sw_n = 1'b1;
        end
    end

    // Output and state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= 1'b0;
            sw_q     <= 1'b0;
            pulse_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            lvl_q    <= lvl_n;
            sw_q     <= sw_n;
            pulse_q  <= pulse_n;
            primed_q <= primed_n;
        end
    end

    assign bias_ctrl         = lvl_q;
    assign sw_allow          = sw_q;
    assign restart_pulse     = pulse_q;
    assign restart_exhausted = exh;

endmodule

// File: rtl/bias_hyst_ctrl_chk.sv
// Module: bias_hyst_ctrl_chk
// Port-level properties of bias_hyst_ctrl, attached with bind below.
module bias_hyst_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       force_low,
    input logic       bias_ctrl,
    input logic       sw_allow,
    input logic       restart_pulse,
    input logic       restart_exhausted
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bias_ctrl && !sw_allow && !restart_exhausted && !restart_pulse)); // R1

    AST_FORCE_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> (!bias_ctrl && !sw_allow)); // R8

    AST_EXHAUST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        restart_exhausted |=> restart_exhausted); // R5

    AST_EXHAUST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_exhausted |-> (!bias_ctrl && !sw_allow)); // R5

    AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (!bias_ctrl && $past(bias_ctrl))); // R4

    AST_NORMAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && bias_ctrl && !force_low && !restart_exhausted)
        |=> (bias_ctrl && sw_allow)); // R6

endmodule

bind bias_hyst_ctrl bias_hyst_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .force_low(force_low),
    .bias_ctrl(bias_ctrl), .sw_allow(sw_allow),
    .restart_pulse(restart_pulse), .restart_exhausted(restart_exhausted)
);

// File: tb/bias_hyst_ctrl_bench.sv
`timescale 1ns/1ps
module bias_hyst_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bias_code = '0;
    logic [1:0] mode = 2'b00;
    logic       ramp_done = 1'b0;
    logic       force_low = 1'b0;
    logic       bias_ctrl, sw_allow, restart_pulse, restart_exhausted;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic exh_prev = 1'b0;
    logic same_cycle = 1'b0;
    logic exp_lvl;

    always #10 clk = ~clk;

    bias_hyst_ctrl u_bias_hyst_ctrl (
        .clk(clk), .rst_n(rst_n), .bias_code(bias_code), .mode(mode),
        .ramp_done(ramp_done), .force_low(force_low), .bias_ctrl(bias_ctrl),
        .sw_allow(sw_allow), .restart_pulse(restart_pulse),
        .restart_exhausted(restart_exhausted)
    );

    // Count restart pulses between edges and note their overlap with exhaustion.
    always @(negedge clk) begin
        if (rst_n && restart_pulse) pulses++;
        if (rst_n && restart_exhausted && !exh_prev && restart_pulse) same_cycle = 1'b1;
        exh_prev = restart_exhausted;
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        hold(3);
        chk(bias_ctrl, 0, "R1 reset level");
        chk(sw_allow, 0, "R1 reset sw");
        chk(restart_pulse, 0, "R1 reset pulse");
        chk(restart_exhausted, 0, "R1 reset exhausted");
        rst_n = 1'b1;
        // R1: unprimed, normal mode, code just below the upper threshold.
        mode = 2'b01; bias_code = 10'd912;
        hold(6);
        chk(bias_ctrl, 0, "R1 unprimed normal");
        chk(sw_allow, 0, "R1 unprimed sw");
        // R3: latency of a sustained crossing, start-up mode.
        mode = 2'b00; ramp_done = 1'b0; bias_code = 10'd913;
        hold(2);
        chk(bias_ctrl, 0, "R3 not before third edge");
        hold(1);
        chk(bias_ctrl, 1, "R3 third edge");
        chk(sw_allow, 1, "R2 sw follows level");
        // R3: single-cycle sag is ignored.
        bias_code = 10'd300;
        hold(1);
        bias_code = 10'd920;
        hold(5);
        chk(bias_ctrl, 1, "R3 glitch ignored");
        chk(pulses, 0, "R3 glitch no restart");
        // R2/R4: start-up sweep with ramp_done high, down then up.
        ramp_done = 1'b1;
        exp_lvl = 1'b1;
        for (int c = 960; c >= 400; c--) begin
            bias_code = 10'(c);
            hold(4);
            if (c < 457) exp_lvl = 1'b0;
            else if (c >= 913) exp_lvl = 1'b1;
            chk(bias_ctrl, exp_lvl, "R2 start-up down");
            chk(sw_allow, exp_lvl, "R2 start-up sw down");
        end
        for (int c = 400; c <= 960; c++) begin
            bias_code = 10'(c);
            hold(4);
            if (c < 457) exp_lvl = 1'b0;
            else if (c >= 913) exp_lvl = 1'b1;
            chk(bias_ctrl, exp_lvl, "R2 start-up up");
        end
        chk(pulses, 0, "R4 ramp_done suppresses count");
        // R6/R9: normal and alternate encoding ignore the code.
        for (int m = 1; m <= 3; m += 2) begin
            mode = 2'(m);
            for (int c = 0; c < 1024; c += 31) begin
                bias_code = 10'(c);
                hold(4);
                chk(bias_ctrl, 1, m == 1 ? "R6 normal level" : "R9 alt level");
                chk(sw_allow, 1, m == 1 ? "R6 normal sw" : "R9 alt sw");
            end
        end
        // R7: burst window sweep.
        mode = 2'b10; exp_lvl = 1'b1;
        for (int c = 520; c >= 440; c--) begin
            bias_code = 10'(c);
            hold(4);
            if (c < 457) exp_lvl = 1'b0;
            else if (c > 495) exp_lvl = 1'b1;
            chk(bias_ctrl, exp_lvl, "R7 burst down");
            chk(sw_allow, 1, "R7 burst sw");
        end
        for (int c = 440; c <= 520; c++) begin
            bias_code = 10'(c);
            hold(4);
            if (c < 457) exp_lvl = 1'b0;
            else if (c > 495) exp_lvl = 1'b1;
            chk(bias_ctrl, exp_lvl, "R7 burst up");
        end
        chk(pulses, 0, "R4 burst falls uncounted");
        // R8: force asserted in the same cycle as a sag.
        mode = 2'b00; ramp_done = 1'b0; bias_code = 10'd920;
        hold(4);
        chk(bias_ctrl, 1, "R8 setup high");
        force_low = 1'b1; bias_code = 10'd300;
        hold(1);
        chk(bias_ctrl, 0, "R8 forced level");
        chk(sw_allow, 0, "R8 forced sw");
        hold(4);
        force_low = 1'b0;
        hold(4);
        chk(bias_ctrl, 0, "R8 stays low after release");
        chk(pulses, 0, "R8 forced sag uncounted");
        bias_code = 10'd920;
        hold(4);
        chk(bias_ctrl, 1, "R8 recovery");
        // R4/R5: ten restarts.
        for (int k = 1; k <= 10; k++) begin
            bias_code = 10'd300;
            hold(4);
            chk(pulses, k, "R4 restart count");
            chk(bias_ctrl, 0, "R4 level after sag");
            chk(restart_exhausted, (k == 10) ? 1 : 0, "R5 exhausted flag");
            if (k < 10) begin
                bias_code = 10'd920;
                hold(4);
                chk(bias_ctrl, 1, "R4 restart resumes");
            end
        end
        chk(same_cycle, 1, "R5 pulse with exhausted");
        bias_code = 10'd920;
        hold(4);
        chk(bias_ctrl, 0, "R5 latched level");
        chk(sw_allow, 0, "R5 latched sw");
        mode = 2'b01;
        hold(4);
        chk(bias_ctrl, 0, "R5 latched in normal");
        chk(restart_exhausted, 1, "R5 flag held");
        rst_n = 1'b0;
        hold(2);
        rst_n = 1'b1;
        hold(1);
        chk(restart_exhausted, 0, "R5 cleared by reset");
        chk(bias_ctrl, 0, "R1 low after reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule